// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by fetching translation entries from a two-level table held in ordinary memory. A requester presents the address, the access kind (read or write) and the privilege (user or supervisor). The walker latches a page-directory base frame and reads the directory entry. Unless that entry maps a 4 MB region directly, it then reads the second-level entry.

Each fetched word is tested for presence first and for permission second. A successful walk returns the physical address along with the write-through and cache-inhibit flags of the final entry. When the final entry still lacks its accessed mark, or lacks its dirty mark on a write, the walker stores the corrected word back to memory before it reports success. A failed walk raises a fault pulse with a cause code and writes nothing.

The memory side is a single-word request port with a valid/ready handshake and a separate read-response strobe. One walk runs at a time.

Top module: `pt_walker`

## Requirements
- R1: For virtual address bits [31:22] = d and [21:12] = t, the directory word is read from byte address {base_frame, 12'b0} + 4*d, and the second-level word from {directory_entry[31:12], 12'b0} + 4*t.
- R2: A completed small-page walk reports phys_addr = {leaf[31:12], va[11:0]}, page_wt = leaf bit 3 and page_cd = leaf bit 4.
- R3: A present directory word with bit 7 (large page) set ends the walk after one read, with phys_addr = {entry[31:22], va[21:0]}.
- R4: A fetched word with bit 0 (present) clear ends the walk with walk_fault and fault_cause = 1, no matter what its other bits hold, and nothing is written to memory.
- R5: A present word at either level raises walk_fault with fault_cause = 2 when the access is a write and bit 1 (writeable) is clear, or when the access is a user access and bit 2 (user) is clear. A supervisor read never takes this fault, and nothing is written.
- R6: When the final entry has bit 5 (accessed) clear, or the access is a write to a small page whose bit 6 (dirty) is clear, exactly one memory write stores the entry with bit 5 set (and, for that write case, bit 6 set) before walk_done. A final entry that needs neither change causes no write.
- R7: A large-page directory entry never has its dirty bit set by the walker, including on write accesses.
- R8: busy is high from the cycle after a request is accepted until the cycle in which walk_done or walk_fault pulses. Requests presented while busy is high are ignored and produce no outcome.
- R9: After reset, busy, walk_done, walk_fault and mem_req_valid are low. walk_done and walk_fault are single-cycle pulses and never coincide.
- R10: mem_req_valid, mem_req_addr and mem_req_we hold steady until mem_req_ready is seen. No request is raised while idle, and walks complete correctly under a stalling ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe, taken when busy is low |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| page_dir_base | input | 20 | Frame number of the directory table, latched at acceptance |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = word write, 0 = word read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data word |
| walk_done | output | 1 | One-cycle pulse: translation succeeded |
| walk_fault | output | 1 | One-cycle pulse: translation failed |
| fault_cause | output | 2 | 1 = not present, 2 = protection; valid with walk_fault |
| phys_addr | output | 32 | Translated address; valid with walk_done |
| page_wt | output | 1 | Write-through flag of the final entry |
| page_cd | output | 1 | Cache-disable flag of the final entry |

## Verification
The bench builds the walker with its default split of 10 directory bits, 10 table bits and a 12-bit offset. At that split the 4 MB large-page path and the small-page path share one directory table, so both can be reached from one base frame. The bench drives walks that finish at each level, fault at each level, and do or do not need a write-back. Walks are also run under a ready that toggles every cycle, so that the request port has to hold its request while it waits.

// File: rtl/pt_walk_pkg.sv
// Package: shared entry bit positions, fault codes and walk state encoding
// for the two-level page table walker. Assumes 32-bit entries.
package pt_walk_pkg;

    localparam int BIT_P  = 0;  // present
    localparam int BIT_W  = 1;  // writeable
    localparam int BIT_U  = 2;  // user accessible
    localparam int BIT_WT = 3;  // write-through
    localparam int BIT_CD = 4;  // cache disable
    localparam int BIT_A  = 5;  // accessed
    localparam int BIT_D  = 6;  // dirty (second level only)
    localparam int BIT_L  = 7;  // large page (directory only)

    typedef enum logic [1:0] {
        CAUSE_NONE        = 2'd0,
        CAUSE_NOT_PRESENT = 2'd1,
        CAUSE_PROTECTION  = 2'd2
    } fault_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_UPD_REQ
    } walk_state_e;

endpackage

// File: rtl/ptw_addr_gen.sv
// Module: ptw_addr_gen
// Purely combinational address arithmetic for the walker: builds the byte
// addresses of the directory and table entries and the final physical
// address for small and large pages.
// Assumes 4-byte entries and DIR_W + TBL_W + OFF_W == ADDR_W.
module ptw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DIR_W  = 10,
    parameter int TBL_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0]       va,
    input  logic [ADDR_W-OFF_W-1:0] base_frame,
    input  logic [ADDR_W-OFF_W-1:0] dir_frame,
    input  logic [ADDR_W-OFF_W-1:0] leaf_frame,
    output logic [ADDR_W-1:0]       dir_addr,
    output logic [ADDR_W-1:0]       tbl_addr,
    output logic [ADDR_W-1:0]       pa_small,
    output logic [ADDR_W-1:0]       pa_large
);
    localparam int LARGE_OFF_W = TBL_W + OFF_W;
    localparam int ENTRY_SH    = 2;

    logic [DIR_W-1:0] dir_idx;
    logic [TBL_W-1:0] tbl_idx;

    // Split the virtual address into its two index fields.
    always_comb begin
        dir_idx = va[ADDR_W-1 -: DIR_W];
        tbl_idx = va[OFF_W +: TBL_W];
    end

    // Form entry addresses from a table frame plus a scaled index.
    always_comb begin
        dir_addr = {base_frame, {OFF_W{1'b0}}} | (ADDR_W'(dir_idx) << ENTRY_SH);
        tbl_addr = {dir_frame,  {OFF_W{1'b0}}} | (ADDR_W'(tbl_idx) << ENTRY_SH);
    end

    // Combine the leaf frame with the untranslated offset bits.
    always_comb begin
        pa_small = {leaf_frame, va[OFF_W-1:0]};
        pa_large = {leaf_frame[ADDR_W-OFF_W-1:TBL_W], va[LARGE_OFF_W-1:0]};
    end

endmodule

// File: rtl/ptw_entry_check.sv
// Module: ptw_entry_check
// Combinational judgement of one fetched entry: presence, permission against
// the access, and whether the final entry needs an accessed/dirty update.
// Assumes the caller gives presence priority over protection.
module ptw_entry_check
    import pt_walk_pkg::*;
#(
    parameter int ENTRY_W = 32
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic               is_leaf,
    input  logic               dirty_ok,
    input  logic               acc_write,
    input  logic               acc_user,
    output logic               not_present,
    output logic               prot_fault,
    output logic               need_update,
    output logic [ENTRY_W-1:0] updated
);
    logic set_a;
    logic set_d;

    // Presence and permission tests.
    always_comb begin
        not_present = !entry[BIT_P];
        prot_fault  = (acc_write && !entry[BIT_W]) || (acc_user && !entry[BIT_U]);
    end

    // Decide which status marks must be raised on the final entry.
    always_comb begin
        set_a       = !entry[BIT_A];
        set_d       = dirty_ok && acc_write && !entry[BIT_D];
        need_update = is_leaf && (set_a || set_d);
        updated     = entry | (ENTRY_W'(1) << BIT_A)
                            | (set_d ? (ENTRY_W'(1) << BIT_D) : '0);
    end

endmodule

// File: rtl/pt_walker.sv
// Module: pt_walker
// Walks a two-level page table for one request at a time: directory read,
// optional second-level read, permission checks, optional write-back of the
// accessed/dirty marks, then a done or fault pulse.
// Assumes a memory that answers each read with mem_rsp_valid one or more
// cycles after the handshake, and completes writes at the handshake.
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIR_W  = 10,
    parameter int TBL_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_va,
    input  logic                    req_write,
    input  logic                    req_user,
    input  logic [ADDR_W-OFF_W-1:0] page_dir_base,
    output logic                    busy,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic                    mem_req_we,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [ADDR_W-1:0]       mem_req_wdata,
    input  logic                    mem_rsp_valid,
    input  logic [ADDR_W-1:0]       mem_rsp_rdata,
    output logic                    walk_done,
    output logic                    walk_fault,
    output logic [1:0]              fault_cause,
    output logic [ADDR_W-1:0]       phys_addr,
    output logic                    page_wt,
    output logic                    page_cd
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    walk_state_e        state;
    logic [ADDR_W-1:0]  va_q;
    logic               wr_q;
    logic               user_q;
    logic [FRAME_W-1:0] base_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [ADDR_W-1:0]  upd_addr_q;
    logic [ADDR_W-1:0]  upd_data_q;
    logic [ADDR_W-1:0]  pa_q;
    logic               wt_q;
    logic               cd_q;
    logic               done_q;
    logic               fault_q;
    fault_cause_e       cause_q;

    logic [ADDR_W-1:0]  dir_addr;
    logic [ADDR_W-1:0]  tbl_addr;
    logic [ADDR_W-1:0]  pa_small;
    logic [ADDR_W-1:0]  pa_large;
    logic               in_dir_wait;
    logic               chk_leaf;
    logic               chk_np;
    logic               chk_prot;
    logic               chk_upd;
    logic [ADDR_W-1:0]  chk_entry;

    ptw_addr_gen #(
        .ADDR_W(ADDR_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)
    ) i_addr_gen (
        .va         (va_q),
        .base_frame (base_q),
        .dir_frame  (dir_frame_q),
        .leaf_frame (mem_rsp_rdata[ADDR_W-1:OFF_W]),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr),
        .pa_small   (pa_small),
        .pa_large   (pa_large)
    );

    // Select leaf semantics: a directory entry is final only for large pages.
    always_comb begin
        in_dir_wait = (state == ST_DIR_WAIT);
        chk_leaf    = in_dir_wait ? mem_rsp_rdata[BIT_L] : 1'b1;
    end

    ptw_entry_check #(
        .ENTRY_W(ADDR_W)
    ) i_entry_check (
        .entry       (mem_rsp_rdata),
        .is_leaf     (chk_leaf),
        .dirty_ok    (!in_dir_wait),
        .acc_write   (wr_q),
        .acc_user    (user_q),
        .not_present (chk_np),
        .prot_fault  (chk_prot),
        .need_update (chk_upd),
        .updated     (chk_entry)
    );

    // Walk sequencer: advances through reads, checks and the write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            va_q        <= '0;
            wr_q        <= 1'b0;
            user_q      <= 1'b0;
            base_q      <= '0;
            dir_frame_q <= '0;
            upd_addr_q  <= '0;
            upd_data_q  <= '0;
            pa_q        <= '0;
            wt_q        <= 1'b0;
            cd_q        <= 1'b0;
            done_q      <= 1'b0;
            fault_q     <= 1'b0;
            cause_q     <= CAUSE_NONE;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        wr_q   <= req_write;
                        user_q <= req_user;
                        base_q <= page_dir_base;
                        state  <= ST_DIR_REQ;
                    end
                end
                ST_DIR_REQ: begin
                    if (mem_req_ready) state <= ST_DIR_WAIT;
                end
                ST_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (chk_np) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_NOT_PRESENT;
                            state   <= ST_IDLE;
                        end else if (chk_prot) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_PROTECTION;
                            state   <= ST_IDLE;
                        end else if (mem_rsp_rdata[BIT_L]) begin
                            pa_q    <= pa_large;
                            wt_q    <= mem_rsp_rdata[BIT_WT];
                            cd_q    <= mem_rsp_rdata[BIT_CD];
                            cause_q <= CAUSE_NONE;
                            if (chk_upd) begin
                                upd_addr_q <= dir_addr;
                                upd_data_q <= chk_entry;
                                state      <= ST_UPD_REQ;
                            end else begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end
                        end else begin
                            dir_frame_q <= mem_rsp_rdata[ADDR_W-1:OFF_W];
                            state       <= ST_TBL_REQ;
                        end
                    end
                end
                ST_TBL_REQ: begin
                    if (mem_req_ready) state <= ST_TBL_WAIT;
                end
                ST_TBL_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (chk_np) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_NOT_PRESENT;
                            state   <= ST_IDLE;
                        end else if (chk_prot) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_PROTECTION;
                            state   <= ST_IDLE;
                        end else begin
                            pa_q    <= pa_small;
                            wt_q    <= mem_rsp_rdata[BIT_WT];
                            cd_q    <= mem_rsp_rdata[BIT_CD];
                            cause_q <= CAUSE_NONE;
                            if (chk_upd) begin
                                upd_addr_q <= tbl_addr;
                                upd_data_q <= chk_entry;
                                state      <= ST_UPD_REQ;
                            end else begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end
                        end
                    end
                end
                ST_UPD_REQ: begin
                    if (mem_req_ready) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory request from the current walk state.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = upd_data_q;
        case (state)
            ST_DIR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dir_addr;
            end
            ST_TBL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tbl_addr;
            end
            ST_UPD_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = upd_addr_q;
            end
            default: ;
        endcase
    end

    // Present the registered result to the requester.
    always_comb begin
        busy        = (state != ST_IDLE);
        walk_done   = done_q;
        walk_fault  = fault_q;
        fault_cause = cause_q;
        phys_addr   = pa_q;
        page_wt     = wt_q;
        page_cd     = cd_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R10
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid); // R10
    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_done && walk_fault)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done); // R9
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_fault |-> (fault_cause == 2'd1 || fault_cause == 2'd2)); // R4
    AST_WB_SETS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_wdata[BIT_A]); // R6
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R8

endmodule

// File: tb/test_pt_walker.sv
// Scoreboard bench for pt_walker: the driver queues expected outcomes, the
// monitor compares each done/fault pulse against the head of the queue.
module test_pt_walker;
    localparam logic [31:0] FP = 32'h01, FW = 32'h02, FU = 32'h04, FWT = 32'h08;
    localparam logic [31:0] FCD = 32'h10, FA = 32'h20, FD = 32'h40, FL = 32'h80;
    localparam logic [19:0] BASE = 20'h00010;

    typedef struct {
        logic        fault;
        logic [1:0]  cause;
        logic [31:0] pa;
        logic        wt;
        logic        cd;
        int          reads;
        int          writes;
        int          rd_base;
        int          wr_base;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        walk_done;
    logic        walk_fault;
    logic [1:0]  fault_cause;
    logic [31:0] phys_addr;
    logic        page_wt;
    logic        page_cd;

    logic        stall = 1'b0;
    logic        pre_we = 1'b0;
    logic [31:0] pre_addr = '0;
    logic [31:0] pre_data = '0;
    logic [31:0] mem [logic [31:0]];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          n_vec = 0;
    int          n_err = 0;
    exp_t        exp_q[$];

    always #10 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_user(req_user), .page_dir_base(BASE),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .walk_done(walk_done), .walk_fault(walk_fault),
        .fault_cause(fault_cause), .phys_addr(phys_addr), .page_wt(page_wt),
        .page_cd(page_cd)
    );

    // Memory model: preload port, handshake counting, one-cycle read latency.
    always @(posedge clk) begin
        if (pre_we) mem[pre_addr] = pre_data;
        mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Driver: queue the expectation, issue one request, wait for its outcome.
    task automatic walk(input logic [31:0] va, input bit wr, input bit usr,
                        input bit f, input logic [1:0] c, input logic [31:0] pa,
                        input bit wt, input bit cd, input int nr, input int nw,
                        input string tag);
        exp_t e;
        e.fault = f; e.cause = c; e.pa = pa; e.wt = wt; e.cd = cd;
        e.reads = nr; e.writes = nw; e.rd_base = rd_cnt; e.wr_base = wr_cnt; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R8", "busy after accept", {31'b0, busy}, 32'h1);
        while (!(walk_done || walk_fault)) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each outcome pulse against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && (walk_done || walk_fault)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected outcome", {31'b0, walk_done}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(walk_fault === e.fault, e.tag, "fault", {31'b0, walk_fault}, {31'b0, e.fault});
                chk(walk_done === !e.fault, "R9", "done", {31'b0, walk_done}, {31'b0, !e.fault});
                if (e.fault)
                    chk(fault_cause === e.cause, e.tag, "cause", {30'b0, fault_cause}, {30'b0, e.cause});
                else begin
                    chk(phys_addr === e.pa, e.tag, "phys_addr", phys_addr, e.pa);
                    chk(page_wt === e.wt && page_cd === e.cd, "R2", "wt/cd",
                        {30'b0, page_wt, page_cd}, {30'b0, e.wt, e.cd});
                end
                chk(rd_cnt - e.rd_base == e.reads, e.tag, "read count",
                    32'(rd_cnt - e.rd_base), 32'(e.reads));
                chk(wr_cnt - e.wr_base == e.writes, e.tag, "write count",
                    32'(wr_cnt - e.wr_base), 32'(e.writes));
                chk(busy === 1'b0, "R8", "busy at outcome", {31'b0, busy}, 32'h0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        // Directory (base 0x10000) and second-level table (0x20000).
        poke(32'h0001_0004, 32'h0002_0000 | FP | FW | FU);
        poke(32'h0002_0008, 32'h0ABC_D000 | FP | FW | FU | FWT | FA | FD);
        poke(32'h0002_000C, 32'h0BBB_B000 | FP | FW);
        poke(32'h0002_0010, 32'h0CCC_C000 | FP | FW | FU | FCD);
        poke(32'h0002_0014, 32'h0DDD_D000 | FA);
        poke(32'h0002_0018, 32'h0EEE_E000 | FP | FU | FA);
        poke(32'h0002_001C, 32'h0777_7000 | FP | FW | FU);
        poke(32'h0001_0008, 32'h0C00_0000 | FP | FU | FCD | FA | FL);
        poke(32'h0001_000C, 32'h1000_0000 | FP | FW | FL);
        poke(32'h0001_0010, 32'h0003_0000 | FW | FU);
        poke(32'h0001_0014, 32'h0004_0000 | FP | FW);
        poke(32'h0004_0000, 32'h0F0F_0000 | FP | FW | FU | FA | FD);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && walk_done === 1'b0 && walk_fault === 1'b0 && mem_req_valid === 1'b0,
            "R9", "reset state", {28'b0, busy, walk_done, walk_fault, mem_req_valid}, 32'h0);

        // R1 R2: small-page read, nothing to update.
        walk(32'h0040_2345, 0, 0, 0, 2'd0, 32'h0ABC_D345, 1, 0, 2, 0, "R1");
        chk(rd(32'h0002_0008) == (32'h0ABC_D000 | FP | FW | FU | FWT | FA | FD), "R6",
            "entry untouched", rd(32'h0002_0008), 32'h0ABC_D06F);
        // R6: write with A and D clear sets both.
        walk(32'h0040_3010, 1, 0, 0, 2'd0, 32'h0BBB_B010, 0, 0, 2, 1, "R6");
        chk(rd(32'h0002_000C) == 32'h0BBB_B063, "R6", "A+D written", rd(32'h0002_000C), 32'h0BBB_B063);
        // R6: read with A clear sets only A.
        walk(32'h0040_4FFC, 0, 1, 0, 2'd0, 32'h0CCC_CFFC, 0, 1, 2, 1, "R6");
        chk(rd(32'h0002_0010) == 32'h0CCC_C037, "R6", "A only written", rd(32'h0002_0010), 32'h0CCC_C037);
        // R6: same page again needs no write-back.
        walk(32'h0040_4000, 0, 1, 0, 2'd0, 32'h0CCC_C000, 0, 1, 2, 0, "R6");
        // R3: large page read ends after one read.
        walk(32'h0081_2345, 0, 1, 0, 2'd0, 32'h0C01_2345, 0, 1, 1, 0, "R3");
        // R7: large page write sets A but never D.
        walk(32'h00C0_0ABC, 1, 0, 0, 2'd0, 32'h1000_0ABC, 0, 0, 1, 1, "R7");
        chk(rd(32'h0001_000C) == 32'h1000_00A3, "R7", "no dirty on large", rd(32'h0001_000C), 32'h1000_00A3);
        // R4: directory not present.
        walk(32'h0100_0000, 1, 1, 1, 2'd1, 32'h0, 0, 0, 1, 0, "R4");
        // R4 R5: absent leaf with W clear on a write reports not-present.
        walk(32'h0040_5000, 1, 0, 1, 2'd1, 32'h0, 0, 0, 2, 0, "R4");
        // R5: write to read-only page, entry unchanged.
        walk(32'h0040_6000, 1, 0, 1, 2'd2, 32'h0, 0, 0, 2, 0, "R5");
        chk(rd(32'h0002_0018) == 32'h0EEE_E025, "R5", "entry unchanged", rd(32'h0002_0018), 32'h0EEE_E025);
        // R5: user access blocked at the directory level.
        walk(32'h0140_0000, 0, 1, 1, 2'd2, 32'h0, 0, 0, 1, 0, "R5");
        // R5: supervisor read ignores the user bit.
        walk(32'h0140_0000, 0, 0, 0, 2'd0, 32'h0F0F_0000, 0, 0, 2, 0, "R5");
        // R10: stalling ready.
        stall = 1'b1;
        walk(32'h0040_7888, 1, 1, 0, 2'd0, 32'h0777_7888, 0, 0, 2, 1, "R10");
        chk(rd(32'h0002_001C) == 32'h0777_7067, "R10", "stalled write-back", rd(32'h0002_001C), 32'h0777_7067);
        walk(32'h0081_0000, 0, 0, 0, 2'd0, 32'h0C01_0000, 0, 1, 1, 0, "R10");
        stall = 1'b0;

        // R8: requests during a walk are ignored.
        begin
            exp_t e;
            e.fault = 0; e.cause = 2'd0; e.pa = 32'h0ABC_D001; e.wt = 1; e.cd = 0;
            e.reads = 2; e.writes = 0; e.rd_base = rd_cnt; e.wr_base = wr_cnt; e.tag = "R8";
            exp_q.push_back(e);
            @(negedge clk);
            req_valid = 1'b1; req_va = 32'h0040_2001; req_write = 0; req_user = 0;
            @(negedge clk);
            req_va = 32'h0100_0000; req_write = 1;
            chk(busy === 1'b1, "R8", "busy while walking", {31'b0, busy}, 32'h1);
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            while (!(walk_done || walk_fault)) @(negedge clk);
            repeat (10) @(negedge clk);
            chk(exp_q.size() == 0 && busy === 1'b0, "R8", "single outcome",
                32'(exp_q.size()), 32'h0);
        end

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule